// File: doc/BRIEF.md
# GPIO Event Detect and Interrupt Unit

This block watches every general-purpose pin of the chip for events that software has asked for. Six event kinds can be enabled per pin: a rising or falling transition of the synchronized pin level, a steady high or steady low synchronized level, and a rising or falling transition seen on the raw pin by a faster sampling clock. Any enabled kind that fires on a pin sets a sticky status bit for that pin. Software clears a status bit by writing a one to it. Pins are grouped into banks of `BANK_W` bits, and each bank raises its own interrupt line while any of its status bits is set.

The register port is a plain single-cycle write strobe with a combinational read path, shared with the rest of the GPIO logic. Because it is a control interface and carries no stream, it has no valid/ready handshake: a write takes effect at the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` in the same cycle. The word address is `{kind, bank}`, with `kind` in the upper three bits and the bank number in the low bits.

Level events keep setting their bit while the level holds. Software that services one must therefore remove the pin condition before clearing the bit, or the bit comes straight back.

Top module: `gev_event_unit`

## Requirements
- R1: After reset, every enable word and every status word reads zero and every `irq` bit is low.
- R2: With the rising-transition enable set (kind 1), a 0-to-1 change of `pin_sync` sets that pin's status bit at the first clock edge where the new level is seen. With the enable clear, the change sets nothing.
- R3: With the falling-transition enable set (kind 2), a 1-to-0 change of `pin_sync` sets the status bit, and a 0-to-1 change does not.
- R4: With kinds 1 and 2 both enabled on a pin, both transitions set the status bit.
- R5: With the high-level enable set (kind 3), the status bit is set while `pin_sync` is 1. Clearing it while the pin is still high leaves it set, and clearing it after the pin has gone low leaves it clear.
- R6: With the low-level enable set (kind 4), the status bit is set while `pin_sync` is 0. Clearing it after the pin has gone high leaves it clear.
- R7: A write to a status word (kind 0) clears exactly the bits written as one. Bits written as zero keep their value.
- R8: When a pin event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq[b]` is high exactly when status word `b` is non-zero. Events in one bank never raise the other bank's line.
- R10: With the raw-rising enable set (kind 5), a high pulse on `pin_raw` that is shorter than one `clk` period, and never seen on `pin_sync`, sets the status bit within six `clk` cycles.
- R11: With the raw-falling enable set (kind 6), a short low pulse on `pin_raw` sets the status bit. Raising the pin does not set it.
- R12: Enable words read back what was written, limited to bits of existing pins. Kind 7 reads zero. Status bits above `NUM_PINS` never set, even with a low-level enable written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock for registers and status |
| samp_clk | input | 1 | Fast sampling clock for raw-pin transitions |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pin_sync | input | NUM_PINS | Pin levels already synchronized to `clk` |
| pin_raw | input | NUM_PINS | Unsynchronized pin levels |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address `{kind[2:0], bank}` |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Read data for `bus_addr` |
| irq | output | NB | One interrupt line per bank |

## Verification
On every cycle, the assertions check the status-register rules. A cleared bit with no coincident event is zero next cycle, a coincident event always wins, and no bit appears without an event. They also check that an interrupt line only drops after a clearing write to its own bank, and that padding bits beyond the last pin stay zero. Whether the right event kind fires for the right pin level history can only be shown by the bench's scenarios. The same holds for level re-assertion after a premature clear, and for capture of raw pulses narrower than a clock period. The bench sweeps every pin through all six kinds and predicts each status word from the pin number.

// File: rtl/gev_pkg.sv
package gev_pkg;
  typedef enum logic [2:0] {
    KD_STATUS = 3'd0,
    KD_RISE   = 3'd1,
    KD_FALL   = 3'd2,
    KD_HIGH   = 3'd3,
    KD_LOW    = 3'd4,
    KD_ARISE  = 3'd5,
    KD_AFALL  = 3'd6,
    KD_NONE   = 3'd7
  } kind_e;

  localparam int unsigned NUM_KINDS_EN = 6;
endpackage

// File: rtl/gev_edge_sync.sv
module gev_edge_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/gev_async_edge.sv
module gev_async_edge #(
  parameter int unsigned W = 64
) (
  input  logic         samp_clk,
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] en_rise_i,
  input  logic [W-1:0] en_fall_i,
  output logic [W-1:0] ev_rise_o,
  output logic [W-1:0] ev_fall_o
);
  // fast domain: two-stage synchronizer plus one history stage
  logic [W-1:0] s0_q, s1_q, s2_q;
  logic [W-1:0] tog_r_q, tog_f_q;

  always_ff @(posedge samp_clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q    <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
      tog_r_q <= '0;
      tog_f_q <= '0;
    end else begin
      s0_q    <= raw_i;
      s1_q    <= s0_q;
      s2_q    <= s1_q;
      tog_r_q <= tog_r_q ^ (s1_q & ~s2_q & en_rise_i);
      tog_f_q <= tog_f_q ^ (~s1_q & s2_q & en_fall_i);
    end
  end

  // main domain: synchronize toggles, a changed toggle is one event
  logic [W-1:0] r1_q, r2_q, r3_q, f1_q, f2_q, f3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= '0; r2_q <= '0; r3_q <= '0;
      f1_q <= '0; f2_q <= '0; f3_q <= '0;
    end else begin
      r1_q <= tog_r_q; r2_q <= r1_q; r3_q <= r2_q;
      f1_q <= tog_f_q; f2_q <= f1_q; f3_q <= f2_q;
    end
  end

  assign ev_rise_o = r2_q ^ r3_q;
  assign ev_fall_o = f2_q ^ f3_q;
endmodule

// File: rtl/gev_status_bank.sv
module gev_status_bank #(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] set_i,
  input  logic [BANK_W-1:0] clr_i,
  output logic [BANK_W-1:0] status_o,
  output logic              irq_o
);
  logic [BANK_W-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;

  // R7: a cleared bit with no event in the same cycle is gone next cycle
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));

  // R8: an event always leaves its bit set, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  // R2: no status bit appears without an event
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/gev_event_unit.sv
module gev_event_unit
  import gev_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54,
  parameter int unsigned BANK_W   = 32,
  localparam int unsigned NB      = (NUM_PINS + BANK_W - 1) / BANK_W,
  localparam int unsigned BB      = (NB > 1) ? $clog2(NB) : 1,
  localparam int unsigned ADDR_W  = 3 + BB
) (
  input  logic                clk,
  input  logic                samp_clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  output logic [NB-1:0]       irq
);
  localparam int unsigned PAD = NB * BANK_W;

  function automatic logic [PAD-1:0] mk_valid();
    logic [PAD-1:0] v;
    for (int i = 0; i < PAD; i++) v[i] = (i < NUM_PINS);
    return v;
  endfunction

  localparam logic [PAD-1:0] VALID = mk_valid();

  kind_e         kind;
  logic [BB-1:0] bank;
  assign kind = kind_e'(bus_addr[ADDR_W-1:BB]);
  assign bank = bus_addr[BB-1:0];

  // enable words: index 0..5 maps to kinds 1..6
  logic [BANK_W-1:0] en_q [NUM_KINDS_EN][NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_KINDS_EN; k++)
        for (int b = 0; b < NB; b++) en_q[k][b] <= '0;
    end else if (bus_wr) begin
      for (int k = 0; k < NUM_KINDS_EN; k++)
        for (int b = 0; b < NB; b++)
          if (kind == kind_e'(k + 1) && bank == BB'(b))
            en_q[k][b] <= bus_wdata & VALID[b*BANK_W +: BANK_W];
    end
  end

  logic [PAD-1:0] en_flat [NUM_KINDS_EN];
  logic [PAD-1:0] lvl, raw, rise, fall, arise, afall, set_all, stat_flat;
  logic [BANK_W-1:0] stat_q [NB];

  assign lvl = PAD'(pin_sync);
  assign raw = PAD'(pin_raw);

  gev_edge_sync #(.W(PAD)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_o(rise), .fall_o(fall)
  );

  gev_async_edge #(.W(PAD)) u_async (
    .samp_clk(samp_clk), .clk(clk), .rst_n(rst_n), .raw_i(raw),
    .en_rise_i(en_flat[4]), .en_fall_i(en_flat[5]),
    .ev_rise_o(arise), .ev_fall_o(afall)
  );

  assign set_all = VALID & ((en_flat[0] & rise) | (en_flat[1] & fall) |
                            (en_flat[2] & lvl)  | (en_flat[3] & ~lvl) |
                            (en_flat[4] & arise) | (en_flat[5] & afall));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar k = 0; k < NUM_KINDS_EN; k++) begin : g_kind
      assign en_flat[k][b*BANK_W +: BANK_W] = en_q[k][b];
    end

    logic [BANK_W-1:0] clr_b;
    assign clr_b = (bus_wr && kind == KD_STATUS && bank == BB'(b)) ? bus_wdata : '0;

    gev_status_bank #(.BANK_W(BANK_W)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_all[b*BANK_W +: BANK_W]), .clr_i(clr_b),
      .status_o(stat_q[b]), .irq_o(irq[b])
    );
    assign stat_flat[b*BANK_W +: BANK_W] = stat_q[b];

    // R9: a bank line only drops after a clearing write to that bank
    a_r9_irq_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[b]) |-> $past(bus_wr && kind == KD_STATUS && bank == BB'(b)));
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank == BB'(b)) begin
        if (kind == KD_STATUS) bus_rdata = stat_q[b];
        for (int k = 0; k < NUM_KINDS_EN; k++)
          if (kind == kind_e'(k + 1)) bus_rdata = en_q[k][b];
      end
    end
  end

  // R12: padding bits above the last pin never hold status
  a_r12_pad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flat & ~VALID) == '0);
endmodule

// File: tb/sim_gev_event_unit.sv
`timescale 1ns/1ps
module sim_gev_event_unit;
  localparam int NP = 54;
  localparam int BW = 32;

  logic        clk = 1'b0, samp_clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pin_sync = '0, pin_raw = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  always #0.5 samp_clk = ~samp_clk;

  gev_event_unit #(.NUM_PINS(NP), .BANK_W(BW)) u0 (
    .clk(clk), .samp_clk(samp_clk), .rst_n(rst_n),
    .pin_sync(pin_sync), .pin_raw(pin_raw),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int kind, input int bank, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {kind[2:0], bank[0]}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int kind, input int bank, output logic [31:0] d);
    bus_addr = {kind[2:0], bank[0]};
    #0.2;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected status word and irq pair for one pin
  task automatic expect_pin(input string req, input int p, input bit on);
    logic [31:0] got;
    int bk, bt;
    bk = p / BW; bt = p % BW;
    rd(0, bk, got);
    check(req, got, on ? (32'h1 << bt) : 32'h0);
    check({req, "/R9"}, {30'h0, irq}, on ? (32'h1 << bk) : 32'h0);
  endtask

  task automatic clear_all();
    wr(0, 0, 32'hFFFF_FFFF);
    wr(0, 1, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1: reset state of every word
    for (int k = 0; k < 7; k++)
      for (int b = 0; b < 2; b++) begin
        rd(k, b, got);
        check("R1 reset word", got, 32'h0);
      end
    check("R1 irq", {30'h0, irq}, 32'h0);

    // sweep every pin through all six kinds
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 6; m++) begin
        int bk, bt;
        bk = p / BW; bt = p % BW;
        pin_sync = '0; pin_raw = '0;
        cyc(8);
        clear_all();
        if (m == 0) begin
          // R2 disabled: transition with no enable sets nothing
          pin_sync[p] = 1'b1; cyc(2);
          expect_pin("R2 disabled", p, 1'b0);
          pin_sync[p] = 1'b0; cyc(2);
        end
        wr(m + 1, bk, 32'h1 << bt);
        case (m)
          0: begin
            pin_sync[p] = 1'b1; cyc(1);
            expect_pin("R2 rise", p, 1'b1);
          end
          1: begin
            pin_sync[p] = 1'b1; cyc(2);
            expect_pin("R3 rise ignored", p, 1'b0);
            pin_sync[p] = 1'b0; cyc(1);
            expect_pin("R3 fall", p, 1'b1);
          end
          2: begin
            pin_sync[p] = 1'b1; cyc(1);
            expect_pin("R5 high", p, 1'b1);
            wr(0, bk, 32'h1 << bt);
            expect_pin("R5 reassert", p, 1'b1);
            pin_sync[p] = 1'b0;
            wr(0, bk, 32'h1 << bt);
            cyc(1);
            expect_pin("R5 cleared", p, 1'b0);
          end
          3: begin
            cyc(1);
            expect_pin("R6 low", p, 1'b1);
            pin_sync[p] = 1'b1;
            wr(0, bk, 32'h1 << bt);
            cyc(1);
            expect_pin("R6 cleared", p, 1'b0);
          end
          4: begin
            #1.0 pin_raw[p] = 1'b1;
            #2.0 pin_raw[p] = 1'b0;
            cyc(7);
            expect_pin("R10 raw rise", p, 1'b1);
          end
          default: begin
            pin_raw[p] = 1'b1; cyc(8);
            expect_pin("R11 rise ignored", p, 1'b0);
            #1.0 pin_raw[p] = 1'b0;
            #2.0 pin_raw[p] = 1'b1;
            cyc(7);
            expect_pin("R11 raw fall", p, 1'b1);
          end
        endcase
        wr(m + 1, bk, 32'h0);
        pin_sync = '0; pin_raw = '0;
        cyc(8);
        clear_all();
      end
    end

    // R4: both transitions with both enables
    wr(1, 1, 32'h100); wr(2, 1, 32'h100);
    pin_sync[40] = 1'b1; cyc(1);
    expect_pin("R4 rise", 40, 1'b1);
    wr(0, 1, 32'h100);
    expect_pin("R4 quiet", 40, 1'b0);
    pin_sync[40] = 1'b0; cyc(1);
    expect_pin("R4 fall", 40, 1'b1);
    wr(1, 1, 0); wr(2, 1, 0); clear_all();

    // R7: zero bits of a clearing write keep their state
    wr(1, 0, 32'h0000_0030);
    pin_sync[4] = 1'b1; pin_sync[5] = 1'b1; cyc(1);
    wr(0, 0, 32'h0000_0000);
    rd(0, 0, got); check("R7 zero write", got, 32'h30);
    wr(0, 0, 32'h0000_0010);
    rd(0, 0, got); check("R7 one bit cleared", got, 32'h20);
    wr(1, 0, 0); pin_sync = '0; cyc(1); clear_all();

    // R8: event and clear in the same cycle
    wr(1, 0, 32'h8);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'b0000; bus_wdata = 32'hFFFF_FFFF;
    pin_sync[3] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(0, 0, got); check("R8 set wins", got, 32'h8);
    wr(1, 0, 0); pin_sync = '0; cyc(1); clear_all();

    // R12: readback masking, padding and unused kind
    wr(4, 1, 32'hFFFF_FFFF);
    rd(4, 1, got); check("R12 enable readback", got, 32'h003F_FFFF);
    cyc(1);
    rd(0, 1, got); check("R12 padding status", got, 32'h003F_FFFF);
    rd(0, 0, got); check("R12 other bank", got, 32'h0);
    wr(7, 1, 32'hFFFF_FFFF);
    rd(7, 1, got); check("R12 kind 7", got, 32'h0);
    wr(3, 0, 32'hA5A5_0F0F);
    rd(3, 0, got); check("R12 enable readback bank0", got, 32'hA5A5_0F0F);
    wr(3, 0, 0); wr(4, 1, 0); clear_all();
    check("R1 idle irq", {30'h0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule